// File: doc/BRIEF.md
# Maskable Three-Source Interrupt Controller

This block holds the interrupt control register of a small 8-bit core and decides when the instruction sequencer should branch to the interrupt routine. It watches three request sources: a timer overflow pulse, an external interrupt pin, and the upper nibble of an input port. Each source latches its own sticky flag. A flag counts only when its own enable bit is set, and the global enable must also be set. When an enabled flag is pending and the global enable is set, the block raises a take request. When the sequencer acknowledges that request, the block clears the global enable in hardware. It also drives the fixed vector address that the sequencer loads into its program counter.

Software sees one 8-bit register. A write replaces the whole register, except that a hardware flag set in the same cycle wins over a software clear. The external pin passes through a synchroniser and is edge-detected, so only a low-to-high transition raises its flag. The port-change source compares the four port pins with a snapshot that is taken every time software reads the port. This source expects the pins to be synchronous to the clock already. A return-from-interrupt strobe sets the global enable again. Flags are never cleared by hardware: the handler must clear them itself before interrupts are enabled again.

Top module: `irq_ctl_top`

## Requirements
- R1: While reset is asserted and after it is applied, the register reads 8'h00 and the take output is low.
- R2: The register layout is bit 7 global enable, bit 6 reserved, bit 5 timer enable, bit 4 pin enable, bit 3 port enable, bit 2 timer flag, bit 1 pin flag, bit 0 port flag. Bit 6 always reads 0, and every other bit reads back the value last written.
- R3: A one-cycle timer overflow pulse sets bit 2 on the clock edge that samples it.
- R4: A rising edge on the external pin sets bit 1 exactly three clock edges after the pin rises. A pin held high does not set the flag again after software clears it. A falling edge has no effect.
- R5: Bit 0 is set at the edge after the port pins differ from the snapshot. The snapshot is loaded from the pins on each port-read strobe. While the pins equal the snapshot, bit 0 stays clear.
- R6: The take output is high exactly when bit 7 is set and at least one flag has its own enable set (bit 2 with bit 5, bit 1 with bit 4, bit 0 with bit 3).
- R7: An acknowledge while take is high clears bit 7 at that edge and leaves the flags set. This holds even when return-from-interrupt is asserted in the same cycle.
- R8: An acknowledge while take is low has no effect on the register.
- R9: A return-from-interrupt strobe sets bit 7 at that edge, unless an accepted acknowledge happens in the same cycle.
- R10: Flags are sticky. Only a software write of 0 clears them, and a hardware set in the same cycle as that write leaves the flag set.
- R11: The vector output is constantly 16'h0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle |
| port_hi_i | input | 4 | Port pins 7:4, synchronous to clk |
| port_rd_i | input | 1 | Port-read strobe, loads the change snapshot |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| take_ack_i | input | 1 | Sequencer accepts the interrupt |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_take_o | output | 1 | Interrupt take request |
| vec_addr_o | output | 16 | Interrupt vector address |

## Verification
Every state bit of this block can be read on the register port, so a wrong flag, enable or global-enable value shows in the read value right after the edge that produced it. The take output is computed from the same bits without any register in between. So a lost flag or a global enable that is not cleared shows as a take request that is wrong in that same cycle. The pin synchroniser is the exception. A wrong depth or a missing edge detector shows only as a flag that appears one edge too early or too late, or as a flag that appears again after software clears it. For that reason the exact latency and the case of a pin held high are checked separately.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_SRC = 3;
  // source index doubles as flag bit position
  localparam int unsigned SRC_PORT = 0;
  localparam int unsigned SRC_PIN  = 1;
  localparam int unsigned SRC_TMR  = 2;
  localparam int unsigned EN_LSB   = 3;
  localparam int unsigned BIT_RSVD = 6;
  localparam int unsigned BIT_GIE  = 7;
  localparam logic [15:0] VEC_DEFAULT = 16'h0004;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R4: a held-high pin yields one pulse only
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins_i,
  input  logic            rd_i,
  output logic            change_o
);
  logic [PINS-1:0] snap_q;
  logic [PINS-1:0] snap_d;
  logic [PINS-1:0] diff;

  always_comb snap_d = rd_i ? pins_i : snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  for (genvar b = 0; b < PINS; b++) begin : g_cmp
    assign diff[b] = pins_i[b] ^ snap_q[b];
  end

  assign change_o = |diff;

  // R5: a read strobe loads the snapshot from the pins
  p_snap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (snap_q == $past(pins_i)));
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               take_o
);
  logic               gie_q, gie_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic               fire;

  assign take_o = gie_q & |(flag_q & en_q);
  assign fire   = ack_i & take_o;

  // global enable: accept beats return, return beats write
  always_comb begin
    if (fire)        gie_d = 1'b0;
    else if (reti_i) gie_d = 1'b1;
    else if (wr_i)   gie_d = wdata_i[BIT_GIE];
    else             gie_d = gie_q;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      en_d[s]   = wr_i ? wdata_i[EN_LSB+s] : en_q[s];
      flag_d[s] = set_i[s] | (wr_i ? wdata_i[s] : flag_q[s]);
    end

    // R10: a hardware set always lands, even against a write of 0
    p_set_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[s] |=> flag_q[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[BIT_GIE]             = gie_q;
    rdata_o[BIT_RSVD]            = 1'b0;
    rdata_o[EN_LSB+:NUM_SRC]     = en_q;
    rdata_o[NUM_SRC-1:0]         = flag_q;
  end

  // R7: accepted request drops the global enable
  p_fire_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && take_o) |=> !gie_q);
  // R7: acceptance leaves pending flags in place
  p_fire_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && take_o && !wr_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R8: stray acknowledge does nothing
  p_ack_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !take_o && !reti_i && !wr_i) |=> $stable(gie_q));
  // R9: return re-enables
  p_reti_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !(ack_i && take_o)) |=> gie_q);
  // R10: flags hold without a write
  p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int unsigned  SYNC_STAGES = 2,
  parameter int unsigned  PORT_PINS   = 4,
  parameter logic [15:0]  VECTOR      = VEC_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_pin_i,
  input  logic                 tmr_ovf_i,
  input  logic [PORT_PINS-1:0] port_hi_i,
  input  logic                 port_rd_i,
  input  logic                 reg_wr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  input  logic                 take_ack_i,
  input  logic                 reti_i,
  output logic                 irq_take_o,
  output logic [15:0]          vec_addr_o
);
  logic               rst_int_n;
  logic               pin_rise;
  logic               port_chg;
  logic [NUM_SRC-1:0] src_set;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  irq_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_int_n), .pin_i(ext_pin_i), .rise_o(pin_rise));

  irq_port_change #(.PINS(PORT_PINS)) u_port (
    .clk(clk), .rst_n(rst_int_n), .pins_i(port_hi_i), .rd_i(port_rd_i),
    .change_o(port_chg));

  always_comb begin
    src_set           = '0;
    src_set[SRC_PORT] = port_chg;
    src_set[SRC_PIN]  = pin_rise;
    src_set[SRC_TMR]  = tmr_ovf_i;
  end

  irq_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .set_i(src_set), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .ack_i(take_ack_i), .reti_i(reti_i),
    .rdata_o(reg_rdata_o), .take_o(irq_take_o));

  assign vec_addr_o = VECTOR;

  // R3: timer pulse becomes a visible flag one edge later
  p_tmr_flag_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmr_ovf_i |=> reg_rdata_o[SRC_TMR]);
  // R6: no take request while globally disabled
  p_take_gated_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_rdata_o[BIT_GIE] |-> !irq_take_o);
endmodule

// File: tb/test_irq_ctl_top.sv
module test_irq_ctl_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       tmr;
    logic [3:0] port;
    logic       rd;
    logic       ack;
    logic       reti;
    logic [7:0] exp_rd;
    logic       exp_take;
  } vec_t;

  // wr wd tmr port rd ack reti | exp_rd exp_take
  localparam int NV = 18;
  localparam vec_t TABLE [NV] = '{
    '{1'b1, 8'hFF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'hBF, 1'b1}, // R2 bit6 reads 0
    '{1'b1, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}, // R10 sw clear
    '{1'b0, 8'h00, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0}, // R3 timer
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0}, // R10 sticky
    '{1'b1, 8'hA4, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'hA4, 1'b1}, // R6 enabled
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h24, 1'b0}, // R7 accept
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 8'h24, 1'b0}, // R8 stray ack
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 8'hA4, 1'b1}, // R9 return
    '{1'b1, 8'h80, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0}, // R6 gie only
    '{1'b0, 8'h00, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0}, // R5 change
    '{1'b1, 8'h88, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 8'h89, 1'b1}, // R10 set beats clear
    '{1'b0, 8'h00, 1'b0, 4'h1, 1'b1, 1'b0, 1'b0, 8'h89, 1'b1}, // R5 snapshot
    '{1'b1, 8'h88, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 8'h88, 1'b0}, // R5 equal stays clear
    '{1'b1, 8'h88, 1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 8'h8C, 1'b0}, // R10 timer vs write
    '{1'b1, 8'hAC, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 8'hAC, 1'b1}, // R6
    '{1'b0, 8'h00, 1'b0, 4'h1, 1'b0, 1'b1, 1'b1, 8'h2C, 1'b0}, // R7 beats return
    '{1'b0, 8'h00, 1'b0, 4'h1, 1'b0, 1'b0, 1'b1, 8'hAC, 1'b1}, // R9
    '{1'b0, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 8'hAD, 1'b1}  // R5 change back
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_pin, tmr_ovf, port_rd, reg_wr, take_ack, reti;
  logic [3:0]  port_hi;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        irq_take;
  logic [15:0] vec_addr;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl_top i_irq_ctl_top (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .tmr_ovf_i(tmr_ovf),
    .port_hi_i(port_hi), .port_rd_i(port_rd), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .take_ack_i(take_ack),
    .reti_i(reti), .irq_take_o(irq_take), .vec_addr_o(vec_addr));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = 0; tmr_ovf = 0; port_rd = 0; take_ack = 0; reti = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; step(); idle();
  endtask

  initial begin
    rst_n = 0; ext_pin = 0; port_hi = 0; idle();
    repeat (3) @(negedge clk);
    check("R1 reset rdata", {8'h0, reg_rdata}, 16'h0000);
    check("R1 reset take", {15'h0, irq_take}, 16'h0000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release", {8'h0, reg_rdata}, 16'h0000);
    check("R11 vector", vec_addr, 16'h0004);

    for (int i = 0; i < NV; i++) begin
      reg_wr = TABLE[i].wr; reg_wdata = TABLE[i].wd; tmr_ovf = TABLE[i].tmr;
      port_hi = TABLE[i].port; port_rd = TABLE[i].rd; take_ack = TABLE[i].ack;
      reti = TABLE[i].reti;
      step();
      check($sformatf("R2/R10 table row %0d rdata", i), {8'h0, reg_rdata}, {8'h0, TABLE[i].exp_rd});
      check($sformatf("R6 table row %0d take", i), {15'h0, irq_take}, {15'h0, TABLE[i].exp_take});
    end
    idle();

    // resync snapshot to 0, then enable only the pin source
    port_hi = 0; port_rd = 1; step(); idle();
    wr_reg(8'h90);
    check("R5 resynced clear", {8'h0, reg_rdata}, 16'h0090);

    // R4 exact latency
    ext_pin = 1;
    step(); step();
    check("R4 flag not before third edge", {15'h0, reg_rdata[1]}, 16'h0000);
    step();
    check("R4 flag on third edge", {8'h0, reg_rdata}, 16'h0092);
    check("R6 pin take", {15'h0, irq_take}, 16'h0001);
    // R4 held high: cleared flag stays clear
    wr_reg(8'h90);
    repeat (4) step();
    check("R4 held high no reset of flag", {8'h0, reg_rdata}, 16'h0090);
    // R4 falling edge
    ext_pin = 0;
    repeat (4) step();
    check("R4 falling edge ignored", {8'h0, reg_rdata}, 16'h0090);
    check("R6 no take after fall", {15'h0, irq_take}, 16'h0000);

    // R1 reset in mid-run
    wr_reg(8'hBF);
    rst_n = 0;
    #1;
    check("R1 async reset rdata", {8'h0, reg_rdata}, 16'h0000);
    check("R1 async reset take", {15'h0, irq_take}, 16'h0000);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule